// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Sequencer

This block frees an I2C bus that a slave device holds stuck, usually with SDA low after a transfer was cut short. When a recovery request arrives, the sequencer takes both bus lines away from the master engine. It releases them: the open-drain driver is off and the pull-down is off. It then watches the lines through a synchronizer. While either line reads low, it issues clock pulses on SCL. Each pulse drives SCL low for one half-bit time and then releases it for one half-bit time. Before every pulse the sequencer samples both lines again.

The sequence ends in one of two ways. It passes as soon as both lines read high. It fails once the pulse limit is used up and the bus is still not free. In both cases the lines go back to the master engine at once, and a one-cycle done pulse is given with the pass/fail result. The sequencer does not generate a STOP condition afterwards.

The half-bit time is programmed in system clocks through `half_period`. For a bus frequency f and a system clock fc, a suitable value is about fc·(10^6 + f)/(2·f·10^6). This is the half-bit delay in microseconds, rounded up, converted to clocks.

Top module: `i2c_unstick_seq`

## Requirements
- R1: After reset, `owning`, `done` and `fail` are 0. The pad controls `scl_oe`, `scl_pd`, `sda_oe` and `sda_pd` follow the matching engine inputs.
- R2: From the cycle after a request is accepted until the sequence ends, `owning` is 1, `sda_oe`, `scl_pd` and `sda_pd` are 0, and the engine inputs have no effect on the pads. `scl_oe` is 1 only during a pulse's low phase.
- R3: The lines are judged only after they pass a SYNC_STAGES-flop synchronizer that is given SYNC_STAGES cycles to settle. If both lines already read high, no pulse is issued and the sequence passes.
- R4: Each pulse holds `scl_oe` at 1 for exactly H clocks and then at 0 for exactly H clocks. H = max(`half_period`, SYNC_STAGES+1).
- R5: Both lines are sampled at the end of every released phase. The sequence ends with a pass at the first sample where both read high. A low SCL keeps the pulses going just as a low SDA does.
- R6: At most MAX_PULSES (default 200) pulses are issued. If the bus is still not free after the last one, the sequence ends with `fail`=1.
- R7: At the end, `done` is 1 for exactly one cycle. In that same cycle `owning` is 0 and the pads follow the engine again.
- R8: `fail` keeps its value after `done` until the next accepted request. It reads 0 from the cycle after that request is accepted.
- R9: A request made while `owning` is 1 is ignored. The running sequence continues unchanged and gives a single `done`.
- R10: A request raised in the same cycle as `done` is accepted and starts a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| recover_req | input | 1 | Start a recovery sequence (sampled while idle) |
| half_period | input | HALF_W | Half-bit time in system clocks |
| scl_in | input | 1 | SCL pad level (asynchronous) |
| sda_in | input | 1 | SDA pad level (asynchronous) |
| eng_scl_oe | input | 1 | Master engine drive-low request for SCL |
| eng_scl_pd | input | 1 | Master engine pull-down request for SCL |
| eng_sda_oe | input | 1 | Master engine drive-low request for SDA |
| eng_sda_pd | input | 1 | Master engine pull-down request for SDA |
| scl_oe | output | 1 | SCL pad drive-low enable |
| scl_pd | output | 1 | SCL pad pull-down enable |
| sda_oe | output | 1 | SDA pad drive-low enable |
| sda_pd | output | 1 | SDA pad pull-down enable |
| owning | output | 1 | Sequencer holds the lines |
| done | output | 1 | One-cycle end-of-sequence pulse |
| fail | output | 1 | Result of the last sequence, 1 = bus still stuck |

## Verification
Two things can fall in the same cycle: the end of one sequence (the `done` pulse, with lines handed back) and the acceptance of a new request. The bench first runs a sequence that fails. On the following run it raises the request exactly in the sampled cycle where `done` is high. It then judges that `owning` rises on the next cycle, that the earlier `fail` clears at that point, and that the new run issues the expected pulse count. The same bench also places the last allowed pulse against the moment the slave lets go: 199, 200 and 201 stuck clocks. This separates a pass at the cap from a fail at the cap.

// File: rtl/i2c_unstick_pkg.sv
package i2c_unstick_pkg;

    // Line index used by the pad multiplexer
    localparam int LINE_SCL = 0;
    localparam int LINE_SDA = 1;
    localparam int NUM_LINES = 2;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETTLE = 3'd1,
        ST_CHECK  = 3'd2,
        ST_LOW    = 3'd3,
        ST_HIGH   = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic sda;
        logic scl;
    } line_pair_t;

    function automatic logic bus_is_free(line_pair_t l);
        return l.scl & l.sda;
    endfunction

endpackage

// File: rtl/i2c_unstick_sync.sv
module i2c_unstick_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '1;
                else     chain[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '1;
                else     chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_unstick_timer.sv
module i2c_unstick_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= (load_val == '0) ? '0 : load_val - 1'b1;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

    // R4
    load_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (load && load_val > 1) |=> !zero);
endmodule

// File: rtl/i2c_unstick_ctrl.sv
module i2c_unstick_ctrl
    import i2c_unstick_pkg::*;
#(
    parameter int HALF_W      = 16,
    parameter int SYNC_STAGES = 2,
    parameter int MAX_PULSES  = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [HALF_W-1:0] half_period,
    input  line_pair_t        bus,
    input  logic              tmr_zero,
    output logic              tmr_load,
    output logic [HALF_W-1:0] tmr_val,
    output logic              own,
    output logic              scl_drive,
    output logic              done,
    output logic              fail
);
    localparam int PCNT_W   = $clog2(MAX_PULSES + 1);
    localparam int MIN_HALF = SYNC_STAGES + 1;
    localparam logic [HALF_W-1:0] MIN_HALF_V   = HALF_W'(MIN_HALF);
    localparam logic [HALF_W-1:0] SETTLE_LEN   = HALF_W'(SYNC_STAGES);
    localparam logic [PCNT_W-1:0] PULSE_LIMIT  = PCNT_W'(MAX_PULSES);

    seq_state_e        state, nxt;
    logic [PCNT_W-1:0] pcnt;
    logic [HALF_W-1:0] hp_eff;
    logic              decide, fin, fin_fail, inc, clr;

    assign hp_eff = (half_period < MIN_HALF_V) ? MIN_HALF_V : half_period;
    assign decide = (state == ST_CHECK) || (state == ST_HIGH && tmr_zero);

    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = hp_eff;
        inc      = 1'b0;
        fin      = 1'b0;
        fin_fail = 1'b0;
        clr      = 1'b0;
        unique case (state)
            ST_IDLE: if (req) begin
                nxt      = ST_SETTLE;
                tmr_load = 1'b1;
                tmr_val  = SETTLE_LEN;
                clr      = 1'b1;
            end
            ST_SETTLE: if (tmr_zero) nxt = ST_CHECK;
            ST_LOW: if (tmr_zero) begin
                nxt      = ST_HIGH;
                tmr_load = 1'b1;
            end
            default: ;
        endcase
        if (decide) begin
            if (bus_is_free(bus)) begin
                nxt = ST_IDLE;
                fin = 1'b1;
            end else if (pcnt == PULSE_LIMIT) begin
                nxt      = ST_IDLE;
                fin      = 1'b1;
                fin_fail = 1'b1;
            end else begin
                nxt      = ST_LOW;
                tmr_load = 1'b1;
                inc      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            pcnt  <= '0;
            done  <= 1'b0;
            fail  <= 1'b0;
        end else begin
            state <= nxt;
            done  <= fin;
            if (clr)      pcnt <= '0;
            else if (inc) pcnt <= pcnt + 1'b1;
            if (clr)      fail <= 1'b0;
            else if (fin) fail <= fin_fail;
        end
    end

    assign own       = (state != ST_IDLE);
    assign scl_drive = (state == ST_LOW);

    // R6
    pulse_cap_chk: assert property (@(posedge clk) disable iff (rst)
        pcnt <= PULSE_LIMIT);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    fail_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(own) |-> !fail);

    // R8
    fail_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!own && !$past(own) && !done) |-> $stable(fail));

    // R9
    busy_req_chk: assert property (@(posedge clk) disable iff (rst)
        (own && req && !fin) |=> own);
endmodule

// File: rtl/i2c_unstick_mux.sv
module i2c_unstick_mux #(
    parameter int N = 2
) (
    input  logic         own,
    input  logic [N-1:0] drive,
    input  logic [N-1:0] eng_oe,
    input  logic [N-1:0] eng_pd,
    output logic [N-1:0] pad_oe,
    output logic [N-1:0] pad_pd
);
    for (genvar i = 0; i < N; i++) begin : g_line
        assign pad_oe[i] = own ? drive[i] : eng_oe[i];
        assign pad_pd[i] = own ? 1'b0     : eng_pd[i];
    end
endmodule

// File: rtl/i2c_unstick_seq.sv
module i2c_unstick_seq
    import i2c_unstick_pkg::*;
#(
    parameter int HALF_W      = 16,
    parameter int SYNC_STAGES = 2,
    parameter int MAX_PULSES  = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              recover_req,
    input  logic [HALF_W-1:0] half_period,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              eng_scl_oe,
    input  logic              eng_scl_pd,
    input  logic              eng_sda_oe,
    input  logic              eng_sda_pd,
    output logic              scl_oe,
    output logic              scl_pd,
    output logic              sda_oe,
    output logic              sda_pd,
    output logic              owning,
    output logic              done,
    output logic              fail
);
    logic [NUM_LINES-1:0] raw_lines, synced, drive, eng_oe, eng_pd, pad_oe, pad_pd;
    line_pair_t           bus;
    logic                 tmr_load, tmr_zero, scl_drive;
    logic [HALF_W-1:0]    tmr_val;

    assign raw_lines[LINE_SCL] = scl_in;
    assign raw_lines[LINE_SDA] = sda_in;

    i2c_unstick_sync #(.STAGES(SYNC_STAGES), .WIDTH(NUM_LINES)) u_sync (
        .clk(clk), .rst(rst), .d(raw_lines), .q(synced)
    );

    assign bus.scl = synced[LINE_SCL];
    assign bus.sda = synced[LINE_SDA];

    i2c_unstick_timer #(.CNT_W(HALF_W)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    i2c_unstick_ctrl #(
        .HALF_W(HALF_W), .SYNC_STAGES(SYNC_STAGES), .MAX_PULSES(MAX_PULSES)
    ) u_ctrl (
        .clk(clk), .rst(rst), .req(recover_req), .half_period(half_period),
        .bus(bus), .tmr_zero(tmr_zero), .tmr_load(tmr_load), .tmr_val(tmr_val),
        .own(owning), .scl_drive(scl_drive), .done(done), .fail(fail)
    );

    assign drive[LINE_SCL]  = scl_drive;
    assign drive[LINE_SDA]  = 1'b0;
    assign eng_oe[LINE_SCL] = eng_scl_oe;
    assign eng_oe[LINE_SDA] = eng_sda_oe;
    assign eng_pd[LINE_SCL] = eng_scl_pd;
    assign eng_pd[LINE_SDA] = eng_sda_pd;

    i2c_unstick_mux #(.N(NUM_LINES)) u_mux (
        .own(owning), .drive(drive), .eng_oe(eng_oe), .eng_pd(eng_pd),
        .pad_oe(pad_oe), .pad_pd(pad_pd)
    );

    assign scl_oe = pad_oe[LINE_SCL];
    assign sda_oe = pad_oe[LINE_SDA];
    assign scl_pd = pad_pd[LINE_SCL];
    assign sda_pd = pad_pd[LINE_SDA];

    // R2
    release_chk: assert property (@(posedge clk) disable iff (rst)
        owning |-> (!sda_oe && !scl_pd && !sda_pd));

    // R7
    handback_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !owning);
endmodule

// File: tb/i2c_unstick_seq_test.sv
module i2c_unstick_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        recover_req = 1'b0;
    logic [15:0] half_period = 16'd3;
    logic        eng_scl_oe = 1'b0, eng_scl_pd = 1'b0, eng_sda_oe = 1'b0, eng_sda_pd = 1'b0;
    logic        scl_oe, scl_pd, sda_oe, sda_pd, owning, done, fail;
    logic        scl_hold = 1'b0;
    logic        never = 1'b0;
    int          stuck_left = 0;
    logic        scl_in, sda_in;

    always #2.5 clk = ~clk;

    assign scl_in = !scl_oe && !scl_hold;
    assign sda_in = !sda_oe && !never && (stuck_left == 0);

    i2c_unstick_seq uut (
        .clk(clk), .rst(rst), .recover_req(recover_req), .half_period(half_period),
        .scl_in(scl_in), .sda_in(sda_in),
        .eng_scl_oe(eng_scl_oe), .eng_scl_pd(eng_scl_pd),
        .eng_sda_oe(eng_sda_oe), .eng_sda_pd(eng_sda_pd),
        .scl_oe(scl_oe), .scl_pd(scl_pd), .sda_oe(sda_oe), .sda_pd(sda_pd),
        .owning(owning), .done(done), .fail(fail)
    );

    int checks = 0, errors = 0, cycles = 0;
    int pulses = 0, width_bad = 0, own_bad = 0, done_cnt = 0;
    int low_run = 0, high_run = 0, exp_w = 3;
    logic prev_oe = 1'b0, prev_own = 1'b0;

    // Monitors and slave model, all at the falling edge
    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (done) done_cnt <= done_cnt + 1;
        if (owning && (sda_oe || scl_pd || sda_pd)) own_bad <= own_bad + 1;
        if (owning && prev_own) begin
            if (scl_oe && !prev_oe) begin
                pulses <= pulses + 1;
                if (pulses > 0 && high_run != exp_w) width_bad <= width_bad + 1;
                low_run <= 1;
            end else if (!scl_oe && prev_oe) begin
                if (low_run != exp_w) width_bad <= width_bad + 1;
                high_run <= 1;
                if (stuck_left > 0) stuck_left <= stuck_left - 1;
            end else if (scl_oe) begin
                low_run <= low_run + 1;
            end else begin
                high_run <= high_run + 1;
            end
        end
        prev_oe  <= scl_oe;
        prev_own <= owning;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic arm(input int stuck, input int hp);
        @(negedge clk);
        never      = (stuck == 255);
        stuck_left = (stuck == 255) ? 0 : stuck;
        half_period = 16'(hp);
        exp_w      = (hp < 3) ? 3 : hp;
        pulses = 0; width_bad = 0; own_bad = 0; done_cnt = 0;
    endtask

    task automatic pulse_req();
        recover_req = 1'b1;
        @(negedge clk);
        recover_req = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 6000) begin
            @(negedge clk);
            n++;
        end
        if (!done) chk({tag, " done timeout"}, 0, 1);
    endtask

    // stuck clocks (255 = never frees), programmed half period, expected fail, expected pulses
    localparam logic [31:0] VEC [10] = '{
        {8'd0,   8'd3, 8'd0, 8'd0},
        {8'd1,   8'd3, 8'd0, 8'd1},
        {8'd5,   8'd4, 8'd0, 8'd5},
        {8'd9,   8'd7, 8'd0, 8'd9},
        {8'd2,   8'd1, 8'd0, 8'd2},
        {8'd3,   8'd0, 8'd0, 8'd3},
        {8'd199, 8'd3, 8'd0, 8'd199},
        {8'd200, 8'd3, 8'd0, 8'd200},
        {8'd201, 8'd3, 8'd1, 8'd200},
        {8'd255, 8'd5, 8'd1, 8'd200}
    };

    initial begin
        fork
            begin
                while (cycles < 150000) @(negedge clk);
                chk("watchdog expired", 1, 0);
                finish_run();
            end
        join_none

        // R1 reset state and pass-through
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 owning after reset", int'(owning), 0);
        chk("R1 done after reset", int'(done), 0);
        chk("R1 fail after reset", int'(fail), 0);
        eng_scl_oe = 1'b1; eng_sda_pd = 1'b1;
        #1;
        chk("R1 scl_oe follows engine", int'(scl_oe), 1);
        chk("R1 sda_pd follows engine", int'(sda_pd), 1);
        chk("R1 sda_oe follows engine", int'(sda_oe), 0);
        eng_scl_oe = 1'b0; eng_sda_pd = 1'b0;

        // Table walk: R3 R4 R5 R6 R2 R7
        for (int i = 0; i < 10; i++) begin
            arm(int'(VEC[i][31:24]), int'(VEC[i][23:16]));
            eng_sda_oe = 1'b1; eng_scl_pd = 1'b1; eng_sda_pd = 1'b1;
            pulse_req();
            eng_scl_oe = 1'b1;
            wait_done($sformatf("vec%0d", i));
            chk($sformatf("R6 R5 vec%0d fail", i), int'(fail), int'(VEC[i][15:8]));
            chk($sformatf("R3 R6 vec%0d pulses", i), pulses, int'(VEC[i][7:0]));
            chk($sformatf("R4 vec%0d widths", i), width_bad, 0);
            chk($sformatf("R2 vec%0d release", i), own_bad, 0);
            chk($sformatf("R7 vec%0d handback", i), int'(owning) * 2 + int'(scl_oe), 1);
            eng_scl_oe = 1'b0; eng_sda_oe = 1'b0; eng_scl_pd = 1'b0; eng_sda_pd = 1'b0;
            @(negedge clk);
            chk($sformatf("R7 vec%0d done one cycle", i), int'(done), 0);
        end

        // R8 fail holds (last vector failed)
        repeat (25) @(negedge clk);
        chk("R8 fail held", int'(fail), 1);

        // R10 request in the done cycle, R8 fail cleared at acceptance
        arm(4, 3);
        pulse_req();
        chk("R8 fail cleared", int'(fail), 0);
        wait_done("r10 first");
        chk("R10 first run pulses", pulses, 4);
        stuck_left = 2;
        pulses = 0;
        recover_req = 1'b1;
        @(negedge clk);
        recover_req = 1'b0;
        chk("R10 accepted in done cycle", int'(owning), 1);
        wait_done("r10 second");
        chk("R10 second run pulses", pulses, 2);

        // R9 request while busy
        arm(10, 3);
        pulse_req();
        repeat (20) @(negedge clk);
        pulse_req();
        wait_done("r9");
        repeat (30) @(negedge clk);
        chk("R9 busy request pulses", pulses, 10);
        chk("R9 single done", done_cnt, 1);
        chk("R9 idle afterwards", int'(owning), 0);

        // R5 SCL held low keeps pulsing
        arm(0, 3);
        scl_hold = 1'b1;
        pulse_req();
        begin
            int n = 0;
            while (pulses < 4 && n < 2000) begin
                @(negedge clk);
                n++;
            end
        end
        scl_hold = 1'b0;
        wait_done("r5 scl");
        chk("R5 scl low pass", int'(fail), 0);
        chk("R5 scl low pulses", int'(pulses >= 4 && pulses <= 5), 1);

        finish_run();
    end
endmodule